// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, judging only by its six-byte destination address and a set of static control inputs. The address arrives one byte per clock on a byte strobe. A frame-start pulse opens each frame. One cycle after the sixth byte is taken, the block gives a single-cycle verdict with a valid strobe.

The tests are ranked. Promiscuous mode wins over everything else. An individual (unicast) address must equal the station address. The all-ones address depends only on its own enable. Any other group address is kept when the all-multicast enable is set. Otherwise it is looked up in a 64-bit hash table. The hash is a CRC-32 over the destination bits, taken least significant bit first within each byte, with no final inversion. A running CRC is updated as each byte arrives, so no address storage is needed.

Top module: `rx_dest_filter`

## Requirements
- R1: When `promisc_en` is high at the edge that takes the sixth byte, the verdict is accept whatever the address.
- R2: If bit 0 of the first received byte is 0, the frame is unicast. It is accepted (R1 aside) only if every received byte k (k = 0 first) equals `station_addr[47-8k -: 8]`.
- R3: A destination of six 0xFF bytes is accepted (R1 aside) exactly when `bcast_en` is high. `allmc_en` and `hash_table` do not affect it.
- R4: A group address (first byte bit 0 = 1) that is not all ones is accepted when `allmc_en` is high.
- R5: Otherwise the hash is computed as follows. Start the CRC at 0xFFFFFFFF. For each bit, least significant bit of a byte first and bytes in arrival order, the feedback is CRC bit 31 XOR the data bit. The CRC shifts left by one, and when the feedback is 1 it is XORed with 0x04C11DB7. The index is CRC[31:26] with no inversion. The frame is accepted if `hash_table[index]` is 1; that is bit (index mod 8) of table byte (index / 8), where byte j is `hash_table[8j+7:8j]`.
- R6: `decision_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. `decision_accept` is 0 whenever `decision_valid` is 0.
- R7: `frame_start` clears the byte count and reloads the CRC. A byte presented in the same cycle as `frame_start` is taken as byte 0 of the new frame.
- R8: Bytes after the sixth are ignored until the next `frame_start`. They produce no further verdict.
- R9: Cycles with `byte_valid` low change neither the byte count nor the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Opens a new frame |
| byte_valid | input | 1 | `byte_data` carries a destination byte this cycle |
| byte_data | input | 8 | Destination address byte |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| promisc_en | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept the all-ones address |
| allmc_en | input | 1 | Accept every other group address |
| hash_table | input | 64 | Multicast hash table, bit n for index n |
| decision_valid | output | 1 | Verdict strobe |
| decision_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The only result is the verdict pair, which is due exactly one clock after the edge that samples the sixth byte. Idle cycles between bytes push that edge later, but the verdict still follows it by one clock. The bench drives every byte on the falling edge and reads the verdict on the falling edge after the sixth byte's rising edge. It then reads again one falling edge later to confirm that the strobe has dropped. For restarts and surplus bytes, the bench reads the strobe on every falling edge of the window and expects it low throughout.

// File: rtl/dest_filter_pkg.sv
package dest_filter_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Fold one byte into the running CRC, least significant bit first.
  function automatic logic [31:0] crc_fold_byte(input logic [31:0] crc_in,
                                                input logic [7:0]  data);
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ data[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // Ranked verdict: promiscuous, unicast match, all-ones, all-group, hash.
  function automatic logic rank_verdict(input logic promisc, input logic group,
                                        input logic match,   input logic ones,
                                        input logic bcast,   input logic allmc,
                                        input logic hash_hit);
    if (promisc)     return 1'b1;
    else if (!group) return match;
    else if (ones)   return bcast;
    else if (allmc)  return 1'b1;
    else             return hash_hit;
  endfunction
endpackage

// File: rtl/dest_byte_tracker.sv
module dest_byte_tracker #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start_i,
  input  logic                         byte_valid_i,
  input  logic [BYTE_W-1:0]            byte_data_i,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr_i,
  output logic                         take_o,
  output logic                         last_o,
  output logic                         group_o,
  output logic                         match_o,
  output logic                         ones_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_next;
  logic              group_q, match_q, ones_q;
  logic              group_base, match_base, ones_base;
  logic [BYTE_W-1:0] st_byte;

  always_comb begin
    cnt_base   = frame_start_i ? '0   : cnt_q;
    group_base = frame_start_i ? 1'b0 : group_q;
    match_base = frame_start_i ? 1'b1 : match_q;
    ones_base  = frame_start_i ? 1'b1 : ones_q;
  end

  always_comb begin
    st_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (cnt_base == CNT_W'(k))
        st_byte = station_addr_i[BYTE_W*(ADDR_BYTES-1-k) +: BYTE_W];
  end

  assign take_o   = byte_valid_i && (cnt_base < CNT_W'(ADDR_BYTES));
  assign last_o   = take_o && (cnt_base == CNT_W'(ADDR_BYTES - 1));
  assign cnt_next = take_o ? cnt_base + 1'b1 : cnt_base;
  assign group_o  = (take_o && cnt_base == '0) ? byte_data_i[0] : group_base;
  assign match_o  = match_base && (!take_o || byte_data_i == st_byte);
  assign ones_o   = ones_base  && (!take_o || byte_data_i == {BYTE_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      group_q <= 1'b0;
      match_q <= 1'b1;
      ones_q  <= 1'b1;
    end else begin
      cnt_q   <= cnt_next;
      group_q <= group_o;
      match_q <= match_o;
      ones_q  <= ones_o;
    end
  end

  // R7
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && !byte_valid_i |=> cnt_q == '0);
  // R8
  surplus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'(ADDR_BYTES) && !frame_start_i |=> cnt_q == CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/dest_hash_crc.sv
module dest_hash_crc #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start_i,
  input  logic                 take_i,
  input  logic [7:0]           byte_data_i,
  output logic [HASH_BITS-1:0] index_o
);
  import dest_filter_pkg::*;

  logic [31:0] crc_q, crc_base, crc_next;

  assign crc_base = frame_start_i ? CRC_SEED : crc_q;
  assign crc_next = take_i ? crc_fold_byte(crc_base, byte_data_i) : crc_base;
  assign index_o  = crc_next[31 -: HASH_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_next;
  end

  // R9
  idle_crc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i && !frame_start_i |=> crc_q == $past(crc_q));
  // R7
  crc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i && !take_i |=> crc_q == CRC_SEED);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int HASH_BITS  = 6,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int TABLE_W   = 1 << HASH_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               byte_valid,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic [ADDR_W-1:0]  station_addr,
  input  logic               promisc_en,
  input  logic               bcast_en,
  input  logic               allmc_en,
  input  logic [TABLE_W-1:0] hash_table,
  output logic               decision_valid,
  output logic               decision_accept
);
  import dest_filter_pkg::*;

  logic                 take_w, last_w, group_w, match_w, ones_w;
  logic [HASH_BITS-1:0] hash_idx_w;
  logic                 hash_hit_w, verdict_w;

  dest_byte_tracker #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) tracker_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data),
    .station_addr_i(station_addr), .take_o(take_w), .last_o(last_w),
    .group_o(group_w), .match_o(match_w), .ones_o(ones_w));

  dest_hash_crc #(.HASH_BITS(HASH_BITS)) crc_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
    .take_i(take_w), .byte_data_i(byte_data[7:0]), .index_o(hash_idx_w));

  assign hash_hit_w = hash_table[hash_idx_w];
  assign verdict_w  = rank_verdict(promisc_en, group_w, match_w, ones_w,
                                   bcast_en, allmc_en, hash_hit_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decision_valid  <= 1'b0;
      decision_accept <= 1'b0;
    end else begin
      decision_valid  <= last_w;
      decision_accept <= last_w && verdict_w;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);
  // R6
  accept_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_accept |-> decision_valid);
  // R6
  valid_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(byte_valid));
  // R1
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid && $past(promisc_en) |-> decision_accept);
  // R3
  bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_w && ones_w && !promisc_en |=> decision_accept == $past(bcast_en));
endmodule

// File: tb/rx_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;
  typedef struct packed {
    logic [47:0] dest;
    logic        p, b, m;
    logic [1:0]  hmode;   // 0 none, 1 only target, 2 all but target, 3 all
    logic        exp;
  } vec_t;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{48'h021122334455, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1},  // R2 match
    '{48'h021122334456, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},  // R2 last byte differs
    '{48'h001122334455, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},  // R2 first byte differs
    '{48'h0A0B0C0D0E0F, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1},  // R1 unicast
    '{48'h0A0B0C0D0E0F, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0},  // R2 not group rules
    '{48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0},  // R3 disabled
    '{48'hFFFFFFFFFFFF, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1},  // R3 enabled
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1},  // R1 broadcast
    '{48'h01005E000001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1},  // R4
    '{48'h01005E000001, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1},  // R5 hit
    '{48'h01005E000001, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0},  // R5 miss
    '{48'h333300000001, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1},  // R5 hit
    '{48'h333300000001, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},  // R5 empty
    '{48'hFFFFFFFFFFFE, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0}   // R5 near-broadcast
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [47:0] station_addr = STATION;
  logic        promisc_en = 1'b0, bcast_en = 1'b0, allmc_en = 1'b0;
  logic [63:0] hash_table = '0;
  logic        decision_valid, decision_accept;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .station_addr(station_addr), .promisc_en(promisc_en),
    .bcast_en(bcast_en), .allmc_en(allmc_en), .hash_table(hash_table),
    .decision_valid(decision_valid), .decision_accept(decision_accept));

  // Hash index from R5, run over the 48-bit address as one bit stream.
  function automatic int ref_index(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic b, m;
      b = d[47 - 8*(n/8) - 7 + (n%8)];
      m = c[31];
      c = {c[30:0], 1'b0} ^ ({32{m ^ b}} & 32'h04C11DB7);
    end
    return int'(c[31:26]);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives six bytes on falling edges; returns the verdict sampled one
  // falling edge after the rising edge that takes the sixth byte.
  task automatic send_frame(input logic [47:0] d, input int gap,
                            output logic v, output logic a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      frame_start = (k == 0);
      byte_valid  = 1'b1;
      byte_data   = d[47-8*k -: 8];
      if (k < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          frame_start = 1'b0;
          byte_valid  = 1'b0;
          byte_data   = 8'hA5;
          check("R6 early", {63'd0, decision_valid}, 64'd0);
        end
    end
    @(negedge clk);
    v = decision_valid;
    a = decision_accept;
    frame_start = 1'b0;
    byte_valid  = 1'b0;
  endtask

  initial begin
    logic v, a;
    repeat (3) @(negedge clk);
    check("R6 reset valid", {63'd0, decision_valid}, 64'd0);
    check("R6 reset accept", {63'd0, decision_accept}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int idx;
      idx = ref_index(VECS[i].dest);
      promisc_en = VECS[i].p;
      bcast_en   = VECS[i].b;
      allmc_en   = VECS[i].m;
      case (VECS[i].hmode)
        2'd0: hash_table = '0;
        2'd1: hash_table = 64'd1 << idx;
        2'd2: hash_table = ~(64'd1 << idx);
        default: hash_table = '1;
      endcase
      send_frame(VECS[i].dest, 0, v, a);
      check($sformatf("R6 valid vec%0d", i), {63'd0, v}, 64'd1);
      check($sformatf("R1-5 verdict vec%0d", i), {63'd0, a}, {63'd0, VECS[i].exp});
      @(negedge clk);
      check("R6 pulse ends", {63'd0, decision_valid}, 64'd0);
    end

    // R9: idle cycles between bytes
    promisc_en = 1'b0; bcast_en = 1'b0; allmc_en = 1'b0; hash_table = '0;
    send_frame(STATION, 2, v, a);
    check("R9 gap valid", {63'd0, v}, 64'd1);
    check("R9 gap accept", {63'd0, a}, 64'd1);
    begin
      int idx;
      idx = ref_index(48'h01005E7F0203);
      hash_table = 64'd1 << idx;
      send_frame(48'h01005E7F0203, 3, v, a);
      check("R9 R5 gap hash", {63'd0, a}, 64'd1);
      hash_table = '0;
    end

    // R7: aborted frame, then restart
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      frame_start = (k == 0); byte_valid = 1'b1; byte_data = 8'h01;
    end
    send_frame(STATION, 0, v, a);
    check("R7 restart valid", {63'd0, v}, 64'd1);
    check("R7 restart accept", {63'd0, a}, 64'd1);

    // R8: surplus bytes produce no verdict and cannot alter the next one
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 surplus", {63'd0, decision_valid}, 64'd0);
      byte_valid = 1'b1; byte_data = 8'h00;
    end
    @(negedge clk);
    check("R8 surplus", {63'd0, decision_valid}, 64'd0);
    byte_valid = 1'b0;
    @(negedge clk);
    check("R8 surplus", {63'd0, decision_valid}, 64'd0);
    send_frame(48'h021122334400, 0, v, a);
    check("R8 next frame reject", {63'd0, a}, 64'd0);
    check("R8 next frame valid", {63'd0, v}, 64'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule